// File: doc/BRIEF.md
# UART Transmit/Receive Buffer and Interrupt Controller

This block holds the byte buffers and interrupt logic of a 16550-style serial port. Received bytes go into a receive FIFO that software drains through a register port. Bytes that software writes go into a transmit FIFO, and the block hands them one at a time to an external transmit shifter. The usable FIFO depth can be set at run time to 16, 32, 64 or 128 bytes. The storage is always 128 entries, and the full condition is measured against the selected depth.

Two interrupt lines leave the block. The receive interrupt fires when the receive level reaches a threshold. That threshold is a programmable base value multiplied by 1, 2, 4 or 8, and it is clamped to the selected depth. The transmit interrupt fires when the transmit path has drained. One condition looks only at the FIFO. The other also waits for the shifter to go idle. An optional start delay holds the first byte written into an idle transmit path until one bit-time tick has been seen.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset, both FIFOs are empty, the config register reads 0x00, `irq_rx`, `irq_tx` and `tx_load` are low, status reads 0x60 with an idle shifter, and the interrupt identification reads 0x01.
- R2: Config bits [1:0] select the depth: 16, 32, 64 or 128 bytes for codes 0, 1, 2 and 3. The receive FIFO holds exactly that many bytes. A data write into a full transmit FIFO is dropped.
- R3: A receive byte that arrives at a full receive FIFO sets status bit 1 (overrun). The bit stays set until a status read (address 3) returns it, and then it clears.
- R4: A config write that changes bits [1:0] empties both FIFOs. Bytes pending in them are never delivered.
- R5: The threshold base is written at address 2, and config bits [3:2] shift it left by 0 to 3. `irq_rx` is high while the receive level is nonzero and at or above min(shifted base, depth). The base resets to 1.
- R6: With config bit 4 at 0, a transmit FIFO that becomes empty raises `irq_tx`.
- R7: With config bit 4 at 1, `irq_tx` rises only once the transmit FIFO is empty and `tx_shift_empty` is high, with no load in flight.
- R8: An identification read (address 2) returns 0x04 if `irq_rx` is high, else 0x02 if `irq_tx` is high, else 0x01. The read clears a pending transmit interrupt.
- R9: With config bit 5 at 0, `tx_load` pulses two cycles after a data write to an idle path. With bit 5 at 1, a write into an idle path is held until a `bit_tick` cycle, and `tx_load` follows two cycles after that tick.
- R10: `tx_load` is a one-cycle pulse that only follows a cycle with `tx_shift_empty` high. It is never high in two consecutive cycles, and it delivers bytes in write order on `tx_byte`.
- R11: A read at address 0 pops the receive FIFO. Every register read presents its data on `reg_rdata` in the cycle after `reg_rd`, and receive bytes come out in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | 0 data, 1 config, 2 threshold (write) / identification (read), 3 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| tx_load | output | 1 | One-cycle load pulse to the shifter |
| tx_byte | output | 8 | Byte for the shifter, valid with `tx_load` |
| tx_shift_empty | input | 1 | Shifter idle |
| bit_tick | input | 1 | One pulse per bit time |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| irq_rx | output | 1 | Receive threshold interrupt |
| irq_tx | output | 1 | Transmit empty interrupt |

## Verification
Each result is due at a fixed cycle. Register read data appears one cycle after the read strobe. `irq_rx` follows the receive byte that crossed the threshold by two clock edges. `tx_load` comes two cycles after the data write or after the releasing tick. `irq_tx` rises one cycle after its empty condition holds. The bench drives every input on the falling edge and samples outputs on the falling edge that follows the number of rising edges the requirement gives. It checks the exact cycle for the start-delay and interrupt timing, and it allows a drain window only where the shifter length governs the timing. A scoreboard queue compares the transmitted bytes in order against the bytes the bench wrote.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_CFG  = 2'd1,
    REG_THR  = 2'd2,
    REG_STAT = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [1:0] rsvd;
    logic       tx_delay;
    logic       tx_irq_mode;
    logic [1:0] thr_scale;
    logic [1:0] depth_sel;
  } cfg_t;

  localparam logic [7:0] IID_NONE = 8'h01;
  localparam logic [7:0] IID_TX   = 8'h02;
  localparam logic [7:0] IID_RX   = 8'h04;

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [CW-1:0]    limit,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    level,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic do_push, do_pop;

  assign full    = (level >= limit);
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (do_pop) dout <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R2: level never passes the selected depth
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    level <= limit);

  // R2: a push at full is dropped
  a_r2_full_drop: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !flush) |=> (level == $past(level)));

endmodule

// File: rtl/rx_trigger.sv
module rx_trigger #(
  parameter int CW = 8,
  parameter int TW = 8,
  parameter int SW = 2,
  localparam int SHIFTW = TW + (1 << SW) - 1,
  localparam int XW = (SHIFTW > CW) ? SHIFTW : CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] base,
  input  logic [SW-1:0] scale,
  input  logic [CW-1:0] limit,
  input  logic [CW-1:0] level,
  output logic          irq_rx
);

  logic [XW-1:0] scaled, lim_x, eff;

  always_comb begin
    scaled = XW'(base) << scale;
    lim_x  = XW'(limit);
    eff    = (scaled > lim_x) ? lim_x : scaled;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_rx <= 1'b0;
    else     irq_rx <= (level != '0) && (XW'(level) >= eff);
  end

  // R5: an empty receive FIFO never leaves the interrupt high
  a_r5_quiet_when_empty: assert property (@(posedge clk) disable iff (rst)
    (level == '0) |=> !irq_rx);

endmodule

// File: rtl/tx_launch.sv
module tx_launch (
  input  logic clk,
  input  logic rst,
  input  logic delay_en,
  input  logic irq_mode,
  input  logic fifo_empty,
  input  logic wr_accept,
  input  logic flush,
  input  logic shift_empty,
  input  logic bit_tick,
  input  logic ident_rd,
  output logic pop,
  output logic tx_load,
  output logic irq_tx
);

  logic armed, cond, cond_q, rise;

  assign pop  = !fifo_empty && shift_empty && !tx_load && !armed && !flush;
  assign cond = irq_mode ? (fifo_empty && shift_empty && !tx_load) : fifo_empty;
  assign rise = cond && !cond_q;

  always_ff @(posedge clk) begin
    if (rst || flush)
      armed <= 1'b0;
    else if (delay_en && wr_accept && fifo_empty && shift_empty && !tx_load)
      armed <= 1'b1;
    else if (bit_tick)
      armed <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_load <= 1'b0;
      cond_q  <= 1'b1;
      irq_tx  <= 1'b0;
    end else begin
      tx_load <= pop;
      cond_q  <= cond;
      if (rise)                  irq_tx <= 1'b1;
      else if (ident_rd || !cond) irq_tx <= 1'b0;
    end
  end

  // R10: load is a single-cycle pulse
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    tx_load |=> !tx_load);

  // R10: a load follows a cycle with the shifter idle
  a_r10_after_idle: assert property (@(posedge clk) disable iff (rst)
    tx_load |-> $past(shift_empty));

  // R9: while the start delay is armed no load is issued
  a_r9_armed_blocks: assert property (@(posedge clk) disable iff (rst)
    armed |=> !tx_load);

  // R8: identification read clears the transmit interrupt
  a_r8_ident_clears: assert property (@(posedge clk) disable iff (rst)
    (ident_rd && !rise) |=> !irq_tx);

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import uart_fifo_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MAX_DEPTH = 128,
  parameter int MIN_DEPTH = 16,
  localparam int AW = $clog2(MAX_DEPTH),
  localparam int CW = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              tx_load,
  output logic [DATA_W-1:0] tx_byte,
  input  logic              tx_shift_empty,
  input  logic              bit_tick,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              irq_rx,
  output logic              irq_tx
);

  cfg_t       cfg_q;
  logic [7:0] base_q;
  logic       overrun;
  logic       rd_sel_q;
  logic [7:0] misc_q;

  logic wr_data, wr_cfg, wr_thr, rd_data, rd_ident, rd_stat, flush;
  logic [CW-1:0] limit;

  logic [DATA_W-1:0] rx_dout;
  logic [CW-1:0] rx_level, tx_level;
  logic rx_full, rx_empty, tx_full, tx_empty, tx_pop;

  assign wr_data  = reg_wr && (reg_addr == REG_DATA);
  assign wr_cfg   = reg_wr && (reg_addr == REG_CFG);
  assign wr_thr   = reg_wr && (reg_addr == REG_THR);
  assign rd_data  = reg_rd && (reg_addr == REG_DATA);
  assign rd_ident = reg_rd && (reg_addr == REG_THR);
  assign rd_stat  = reg_rd && (reg_addr == REG_STAT);
  assign flush    = wr_cfg && (reg_wdata[1:0] != cfg_q.depth_sel);
  assign limit    = CW'(MIN_DEPTH) << cfg_q.depth_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      base_q <= 8'd1;
    end else begin
      if (wr_cfg) cfg_q  <= cfg_t'({2'b00, reg_wdata[5:0]});
      if (wr_thr) base_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                       overrun <= 1'b0;
    else if (rx_valid && rx_full)  overrun <= 1'b1;
    else if (rd_stat)              overrun <= 1'b0;
  end

  byte_fifo #(.WIDTH(DATA_W), .DEPTH(MAX_DEPTH)) u_rx_fifo (
    .clk(clk), .rst(rst), .flush(flush), .limit(limit),
    .push(rx_valid), .din(rx_byte), .pop(rd_data), .dout(rx_dout),
    .level(rx_level), .full(rx_full), .empty(rx_empty)
  );

  byte_fifo #(.WIDTH(DATA_W), .DEPTH(MAX_DEPTH)) u_tx_fifo (
    .clk(clk), .rst(rst), .flush(flush), .limit(limit),
    .push(wr_data), .din(reg_wdata[DATA_W-1:0]), .pop(tx_pop), .dout(tx_byte),
    .level(tx_level), .full(tx_full), .empty(tx_empty)
  );

  rx_trigger #(.CW(CW), .TW(8), .SW(2)) u_rx_trigger (
    .clk(clk), .rst(rst), .base(base_q), .scale(cfg_q.thr_scale),
    .limit(limit), .level(rx_level), .irq_rx(irq_rx)
  );

  tx_launch u_tx_launch (
    .clk(clk), .rst(rst), .delay_en(cfg_q.tx_delay), .irq_mode(cfg_q.tx_irq_mode),
    .fifo_empty(tx_empty), .wr_accept(wr_data && !tx_full), .flush(flush),
    .shift_empty(tx_shift_empty), .bit_tick(bit_tick), .ident_rd(rd_ident),
    .pop(tx_pop), .tx_load(tx_load), .irq_tx(irq_tx)
  );

  logic [7:0] iid, status;
  assign iid    = irq_rx ? IID_RX : (irq_tx ? IID_TX : IID_NONE);
  assign status = {1'b0, tx_empty && tx_shift_empty && !tx_load, tx_empty,
                   3'b000, overrun, !rx_empty};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_sel_q <= 1'b0;
      misc_q   <= '0;
    end else if (reg_rd) begin
      rd_sel_q <= rd_data;
      case (reg_addr)
        REG_CFG:  misc_q <= cfg_q;
        REG_THR:  misc_q <= iid;
        REG_STAT: misc_q <= status;
        default:  misc_q <= '0;
      endcase
    end
  end

  assign reg_rdata = rd_sel_q ? 8'(rx_dout) : misc_q;

  // R3: overrun holds until a status read
  a_r3_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    (overrun && !rd_stat) |=> overrun);

  // R3: a byte arriving at full sets overrun
  a_r3_overrun_set: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_full) |=> overrun);

  // R4: a depth change leaves both FIFOs empty
  a_r4_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (rx_empty && tx_empty));

endmodule

// File: tb/uart_fifo_ctl_bench.sv
module uart_fifo_ctl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SHIFT_CYC  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic tx_load;
  logic [7:0] tx_byte;
  logic tx_shift_empty;
  logic bit_tick = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic irq_rx, irq_tx;

  int checks = 0;
  int fails = 0;
  int load_cnt = 0;
  int busy = 0;
  logic stall = 1'b0;
  logic [7:0] exp_tx[$];
  logic [7:0] exp_rx[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_fifo_ctl u_uart_fifo_ctl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_load(tx_load), .tx_byte(tx_byte),
    .tx_shift_empty(tx_shift_empty), .bit_tick(bit_tick), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  // shifter model
  assign tx_shift_empty = (busy == 0) && !stall;
  always @(posedge clk) begin
    if (rst)          busy <= 0;
    else if (tx_load) busy <= SHIFT_CYC;
    else if (busy > 0) busy <= busy - 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_test();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // scoreboard monitor for transmitted bytes (R10)
  always @(negedge clk) begin
    if (!rst && tx_load) begin
      load_cnt++;
      if (exp_tx.size() == 0) check(1'b0, "R10 unexpected load", tx_byte, 0);
      else begin
        logic [7:0] e;
        e = exp_tx.pop_front();
        check(tx_byte == e, "R10 byte order", tx_byte, e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic tx_send(input logic [7:0] b, input bit expect_out);
    if (expect_out) exp_tx.push_back(b);
    reg_write(2'd0, b);
  endtask

  task automatic rx_fill(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'(seed + i * 7);
      exp_rx.push_back(b);
      rx_push(b);
    end
  endtask

  task automatic rx_drain(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d, e;
      e = exp_rx.pop_front();
      reg_read(2'd0, d);
      check(d == e, req, d, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_test();
  end

  initial begin
    logic [7:0] d;
    int base_cnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(irq_rx == 1'b0 && irq_tx == 1'b0 && tx_load == 1'b0, "R1 outputs", {irq_rx, irq_tx, tx_load}, 0);
    reg_read(2'd1, d); check(d == 8'h00, "R1 config", d, 8'h00);
    reg_read(2'd3, d); check(d == 8'h60, "R1 status", d, 8'h60);
    reg_read(2'd2, d); check(d == 8'h01, "R1 ident", d, 8'h01);

    // R5 base threshold 1, R11 read order, R8 rx ident
    exp_rx.push_back(8'hA5);
    rx_push(8'hA5);
    check(irq_rx == 1'b0, "R5 irq_rx one edge after push", irq_rx, 0);
    @(negedge clk);
    check(irq_rx == 1'b1, "R5 irq_rx two edges after push", irq_rx, 1);
    reg_read(2'd2, d); check(d == 8'h04, "R8 ident rx", d, 8'h04);
    rx_drain(1, "R11 rx data");

    // R5 scaled threshold: base 3 x2 = 6
    reg_write(2'd2, 8'd3);
    reg_write(2'd1, 8'h04);
    rx_fill(5, 8'h10);
    idle(2);
    check(irq_rx == 1'b0, "R5 below scaled threshold", irq_rx, 0);
    rx_fill(1, 8'h40);
    @(negedge clk);
    check(irq_rx == 1'b1, "R5 at scaled threshold", irq_rx, 1);
    rx_drain(6, "R11 rx order");

    // R5 clamp: base 10 x8 = 80 clamped to 16; R3 overrun; R2 depth 16
    reg_write(2'd2, 8'd10);
    reg_write(2'd1, 8'h0C);
    rx_fill(15, 8'h20);
    idle(2);
    check(irq_rx == 1'b0, "R5 clamp below depth", irq_rx, 0);
    rx_fill(1, 8'h90);
    @(negedge clk);
    check(irq_rx == 1'b1, "R5 clamp at depth", irq_rx, 1);
    rx_push(8'hEE);
    reg_read(2'd3, d); check(d[1] == 1'b1, "R3 overrun set", d, 8'h02);
    reg_read(2'd3, d); check(d[1] == 1'b0, "R3 overrun cleared by read", d, 0);
    rx_drain(16, "R2 depth 16 data");
    reg_read(2'd3, d); check(d[0] == 1'b0, "R2 depth 16 holds 16", d[0], 0);

    // R2 depth 32
    reg_write(2'd1, 8'h01);
    reg_read(2'd1, d); check(d == 8'h01, "R2 config readback", d, 8'h01);
    rx_fill(32, 8'h03);
    reg_read(2'd3, d); check(d[1] == 1'b0, "R2 depth 32 no overrun at 32", d, 0);
    rx_push(8'h55);
    reg_read(2'd3, d); check(d[1] == 1'b1, "R2 depth 32 overrun at 33", d, 8'h02);
    rx_drain(32, "R2 depth 32 data");

    // R4 depth change flushes
    rx_fill(3, 8'h70);
    stall = 1'b1;
    tx_send(8'h11, 1'b0);
    tx_send(8'h22, 1'b0);
    reg_write(2'd1, 8'h00);
    exp_rx.delete();
    reg_read(2'd3, d);
    check(d[0] == 1'b0 && d[5] == 1'b1, "R4 both FIFOs emptied", d, 8'h20);
    base_cnt = load_cnt;
    stall = 1'b0;
    idle(12);
    check(load_cnt == base_cnt, "R4 flushed bytes not sent", load_cnt - base_cnt, 0);

    // R8 ident tx then clear; R9 immediate start; R6 mode 0 timing
    reg_read(2'd2, d); check(d == 8'h02, "R8 ident tx", d, 8'h02);
    check(irq_tx == 1'b0, "R8 read clears irq_tx", irq_tx, 0);
    tx_send(8'h3C, 1'b1);
    check(tx_load == 1'b0, "R9 no load one cycle after write", tx_load, 0);
    @(negedge clk);
    check(tx_load == 1'b1, "R9 load two cycles after write", tx_load, 1);
    check(irq_tx == 1'b0, "R6 irq_tx not yet", irq_tx, 0);
    @(negedge clk);
    check(irq_tx == 1'b1, "R6 irq_tx on FIFO empty", irq_tx, 1);
    check(tx_load == 1'b0, "R10 pulse ends", tx_load, 0);
    reg_read(2'd2, d); check(d == 8'h02, "R8 ident tx mode 0", d, 8'h02);
    idle(12);

    // R7 mode 1 waits for shifter
    reg_write(2'd1, 8'h10);
    tx_send(8'h5A, 1'b1);
    idle(4);
    check(irq_tx == 1'b0, "R7 irq_tx held while shifting", irq_tx, 0);
    idle(SHIFT_CYC + 4);
    check(irq_tx == 1'b1, "R7 irq_tx after shifter idle", irq_tx, 1);
    reg_read(2'd2, d);
    check(irq_tx == 1'b0, "R8 clear in mode 1", irq_tx, 0);
    idle(4);

    // R9 start delay
    reg_write(2'd1, 8'h20);
    tx_send(8'h77, 1'b1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(tx_load == 1'b0, "R9 load held until tick", tx_load, 0);
    end
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
    check(tx_load == 1'b0, "R9 no load in tick edge", tx_load, 0);
    @(negedge clk);
    check(tx_load == 1'b1, "R9 load two cycles after tick", tx_load, 1);
    idle(12);
    reg_read(2'd2, d);

    // R2 transmit drop at full, R10 order
    reg_write(2'd1, 8'h00);
    stall = 1'b1;
    base_cnt = load_cnt;
    for (int i = 0; i < 17; i++) tx_send(8'(8'hC0 + i), i < 16);
    stall = 1'b0;
    idle(16 * (SHIFT_CYC + 3) + 20);
    check(load_cnt - base_cnt == 16, "R2 write at full dropped", load_cnt - base_cnt, 16);
    check(exp_tx.size() == 0, "R10 all bytes delivered", exp_tx.size(), 0);

    // R2 depth 128
    reg_write(2'd1, 8'h03);
    rx_fill(128, 8'h01);
    reg_read(2'd3, d); check(d[1] == 1'b0, "R2 depth 128 no overrun at 128", d, 0);
    rx_push(8'hFF);
    reg_read(2'd3, d); check(d[1] == 1'b1, "R2 depth 128 overrun at 129", d, 8'h02);
    rx_drain(128, "R2 depth 128 data");

    idle(4);
    finish_test();
  end

endmodule